// File: doc/BRIEF.md
# Multiply-Add Special-Operand Resolver

This block sits in front of the datapath of a single-precision fused multiply-add that computes a*b + c. It looks at the three operands, three negation controls, the rounding mode and a flush-to-zero enable. It then decides whether special operands alone fix the result. Special operands are NaNs, infinities, exact zeros, and a zero product meeting a subnormal addend. When they do, the block delivers the final result word and the exception flags. When they do not, it raises `pass_thru` so the finite multiply, add and round path takes over. In both cases it supplies the effective product sign, the effective addend sign and the result sign flip.

The negations act inside the operation, not on the operands or the result word as seen from outside. For that reason a propagated NaN keeps its own sign. The sign of an exact-zero sum follows the rounding mode.

The decision is held in a registered enumerated state, so results appear one clock after the operands are sampled. The states are:
- `DEC_IDLE`: entered at reset.
- `DEC_NAN`: a NaN operand is propagated.
- `DEC_INVALID`: the result is the default NaN.
- `DEC_INF_C`: an infinite addend wins.
- `DEC_INF_P`: an infinite product wins.
- `DEC_ZERO_SUM`: zero plus zero.
- `DEC_FLUSH`: a flushed subnormal addend.
- `DEC_ADDEND`: the addend is returned.
- `DEC_PASS`: finite path.

Each clock edge with reset released moves the state directly to the decision for the sampled operands. Any state may move to any other. Reset returns the state to `DEC_IDLE`.

Top module: `fma_special_resolve`

## Requirements
- R1: While reset is asserted every output is zero. Outside reset, all outputs reflect the operands sampled at the previous rising clock edge.
- R2: If any operand is a NaN (exponent all ones, fraction nonzero), the result is the first NaN in the order a, b, c. Its quiet bit (fraction MSB, bit 22) is forced to 1 and its sign and remaining payload are unchanged, whatever the negation controls. `flg_invalid` is 1 exactly when some operand is a signaling NaN (quiet bit 0) or the product is infinity times zero.
- R3: If one multiplicand is an exact zero, the other is an infinity and no operand is a NaN, then `flg_invalid` is 1 and the result is the default NaN 0x7FC00000.
- R4: `neg_ctl[0]` negates the addend, `neg_ctl[1]` negates the product and `neg_ctl[2]` negates the result. The outputs are driven in every non-reset state:
  - `prod_sign` = sign(a) XOR sign(b) XOR `neg_ctl[1]`
  - `addend_sign` = sign(c) XOR `neg_ctl[0]`
  - `res_flip` = `neg_ctl[2]`
- R5: If c is infinite and the product is an infinity whose effective sign differs from the effective addend sign, the result is the default NaN with `flg_invalid` set.
- R6: Otherwise, an infinite c gives an infinity with sign `addend_sign` XOR `res_flip`.
- R7: An infinite product with a finite c gives an infinity with sign `prod_sign` XOR `res_flip`.
- R8: A zero product plus an exact-zero c gives a zero whose sign, before the result flip, is chosen as follows. If the effective signs match, it is the common sign. Otherwise it is 1 when `rnd_mode` is 2'b10 (round toward negative) and 0 for the other codes. The result flip is then applied.
- R9: A zero product plus a subnormal c with `ftz_en` set gives a zero with sign `addend_sign` XOR `res_flip` and sets `flg_outdenorm`.
- R10: A zero product plus any other nonzero finite c returns the magnitude of c unchanged, with sign `addend_sign` XOR `res_flip`, and no flags.
- R11: In all remaining cases `pass_thru` is 1, `res_word` is 0 and both flags are 0. At most one of `pass_thru`, `flg_invalid` and `flg_outdenorm` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | Multiplicand a |
| op_b | input | 32 | Multiplicand b |
| op_c | input | 32 | Addend c |
| neg_ctl | input | 3 | Negation controls: bit 0 addend, bit 1 product, bit 2 result |
| rnd_mode | input | 2 | Rounding mode, 2'b10 = toward negative |
| ftz_en | input | 1 | Flush subnormal results to zero |
| res_word | output | 32 | Final result when special, else zero |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_outdenorm | output | 1 | Output-denormal flag |
| pass_thru | output | 1 | Result must come from the finite datapath |
| prod_sign | output | 1 | Effective product sign |
| addend_sign | output | 1 | Effective addend sign |
| res_flip | output | 1 | Result sign flip |

## Verification
The bench sweeps every combination of twelve representative operand values for each of a, b and c. The values are both zeros, both infinities, normals, subnormals of each sign, and quiet and signaling NaNs of each sign. Each combination runs with all negation settings, rounding modes and flush settings. The sweep targets the places where a design typically goes wrong:
- A design that applied the negations to a NaN would emit a NaN with a flipped sign.
- One that ranked the NaN operands wrongly would propagate the wrong payload.
- One that ignored the rounding mode would give +0 where round-down needs -0 for cancelling zeros.
- One that tested the raw addend sign instead of the effective one would miss the opposite-infinity invalid case, or return a wrong-signed addend.

// File: rtl/fmasr_pkg.sv
package fmasr_pkg;

    typedef struct packed {
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } opclass_t;

    typedef enum logic [3:0] {
        DEC_IDLE,
        DEC_NAN,
        DEC_INVALID,
        DEC_INF_C,
        DEC_INF_P,
        DEC_ZERO_SUM,
        DEC_FLUSH,
        DEC_ADDEND,
        DEC_PASS
    } dec_e;

    localparam logic [1:0] RM_DOWN = 2'b10;

endpackage

// File: rtl/fmasr_classify.sv
module fmasr_classify
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output opclass_t              cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_max;
    logic              ex_min;
    logic              fr_nz;

    assign ex     = word[W-2:FRAC_W];
    assign fr     = word[FRAC_W-1:0];
    assign ex_max = &ex;
    assign ex_min = ~|ex;
    assign fr_nz  = |fr;

    assign cls.is_zero = ex_min & ~fr_nz;
    assign cls.is_inf  = ex_max & ~fr_nz;
    assign cls.is_nan  = ex_max & fr_nz;
    assign cls.is_snan = ex_max & fr_nz & ~fr[FRAC_W-1];
endmodule

// File: rtl/fmasr_nan_pick.sv
module fmasr_nan_pick
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  opclass_t              cls_a,
    input  opclass_t              cls_b,
    input  opclass_t              cls_c,
    output logic [EXP_W+FRAC_W:0] nan_word,
    output logic                  any_snan
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QUIET_BIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        if (cls_a.is_nan) begin
            nan_word = op_a | QUIET_BIT;
        end else if (cls_b.is_nan) begin
            nan_word = op_b | QUIET_BIT;
        end else begin
            nan_word = op_c | QUIET_BIT;
        end
    end

    assign any_snan = cls_a.is_snan | cls_b.is_snan | cls_c.is_snan;
endmodule

// File: rtl/fmasr_sign_ctl.sv
module fmasr_sign_ctl (
    input  logic       sign_a,
    input  logic       sign_b,
    input  logic       sign_c,
    input  logic [2:0] neg_ctl,
    output logic       prod_sgn,
    output logic       add_sgn,
    output logic       flip
);
    assign prod_sgn = sign_a ^ sign_b ^ neg_ctl[1];
    assign add_sgn  = sign_c ^ neg_ctl[0];
    assign flip     = neg_ctl[2];
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  logic [2:0]            neg_ctl,
    input  logic [1:0]            rnd_mode,
    input  logic                  ftz_en,
    output logic [EXP_W+FRAC_W:0] res_word,
    output logic                  flg_invalid,
    output logic                  flg_outdenorm,
    output logic                  pass_thru,
    output logic                  prod_sign,
    output logic                  addend_sign,
    output logic                  res_flip
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [W-1:0] ops [3];
    opclass_t     cls [3];

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar g = 0; g < 3; g++) begin : g_cls
        fmasr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word (ops[g]),
            .cls  (cls[g])
        );
    end

    logic [W-1:0] nan_word;
    logic         any_snan;

    fmasr_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .cls_c    (cls[2]),
        .nan_word (nan_word),
        .any_snan (any_snan)
    );

    logic psgn_d, csgn_d, flip_d;

    fmasr_sign_ctl u_sgn (
        .sign_a   (op_a[W-1]),
        .sign_b   (op_b[W-1]),
        .sign_c   (op_c[W-1]),
        .neg_ctl  (neg_ctl),
        .prod_sgn (psgn_d),
        .add_sgn  (csgn_d),
        .flip     (flip_d)
    );

    logic any_nan, inf_zero, p_inf, p_zero, c_sub;

    assign any_nan  = cls[0].is_nan | cls[1].is_nan | cls[2].is_nan;
    assign inf_zero = (cls[0].is_zero & cls[1].is_inf) | (cls[0].is_inf & cls[1].is_zero);
    assign p_inf    = cls[0].is_inf | cls[1].is_inf;
    assign p_zero   = cls[0].is_zero | cls[1].is_zero;
    assign c_sub    = (op_c[W-2:FRAC_W] == '0) & ~cls[2].is_zero;

    // Next-decision logic
    dec_e dec_d, dec_q;
    logic sgn_d, sgn_q;
    logic nan_inv_d, nan_inv_q;

    always_comb begin
        dec_d     = DEC_PASS;
        sgn_d     = 1'b0;
        nan_inv_d = any_snan | inf_zero;
        if (any_nan) begin
            dec_d = DEC_NAN;
        end else if (inf_zero) begin
            dec_d = DEC_INVALID;
        end else if (cls[2].is_inf) begin
            if (p_inf && (psgn_d != csgn_d)) begin
                dec_d = DEC_INVALID;
            end else begin
                dec_d = DEC_INF_C;
                sgn_d = csgn_d ^ flip_d;
            end
        end else if (p_inf) begin
            dec_d = DEC_INF_P;
            sgn_d = psgn_d ^ flip_d;
        end else if (p_zero) begin
            if (cls[2].is_zero) begin
                dec_d = DEC_ZERO_SUM;
                if (psgn_d == csgn_d) begin
                    sgn_d = psgn_d ^ flip_d;
                end else begin
                    sgn_d = (rnd_mode == RM_DOWN) ^ flip_d;
                end
            end else if (c_sub && ftz_en) begin
                dec_d = DEC_FLUSH;
                sgn_d = csgn_d ^ flip_d;
            end else begin
                dec_d = DEC_ADDEND;
                sgn_d = csgn_d ^ flip_d;
            end
        end
    end

    // State register
    logic [W-1:0] nan_q;
    logic [W-2:0] cmag_q;
    logic         psgn_q, csgn_q, flip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q     <= DEC_IDLE;
            sgn_q     <= 1'b0;
            nan_inv_q <= 1'b0;
            nan_q     <= '0;
            cmag_q    <= '0;
            psgn_q    <= 1'b0;
            csgn_q    <= 1'b0;
            flip_q    <= 1'b0;
        end else begin
            dec_q     <= dec_d;
            sgn_q     <= sgn_d;
            nan_inv_q <= nan_inv_d;
            nan_q     <= nan_word;
            cmag_q    <= op_c[W-2:0];
            psgn_q    <= psgn_d;
            csgn_q    <= csgn_d;
            flip_q    <= flip_d;
        end
    end

    // Outputs from the registered decision
    always_comb begin
        res_word      = '0;
        flg_invalid   = 1'b0;
        flg_outdenorm = 1'b0;
        pass_thru     = 1'b0;
        unique case (dec_q)
            DEC_IDLE: begin
                res_word = '0;
            end
            DEC_NAN: begin
                res_word    = nan_q;
                flg_invalid = nan_inv_q;
            end
            DEC_INVALID: begin
                res_word    = DEF_NAN;
                flg_invalid = 1'b1;
            end
            DEC_INF_C, DEC_INF_P: begin
                res_word = {sgn_q, INF_MAG};
            end
            DEC_ZERO_SUM: begin
                res_word = {sgn_q, {(W-1){1'b0}}};
            end
            DEC_FLUSH: begin
                res_word      = {sgn_q, {(W-1){1'b0}}};
                flg_outdenorm = 1'b1;
            end
            DEC_ADDEND: begin
                res_word = {sgn_q, cmag_q};
            end
            DEC_PASS: begin
                pass_thru = 1'b1;
            end
            default: begin
                res_word = '0;
            end
        endcase
    end

    assign prod_sign   = psgn_q;
    assign addend_sign = csgn_q;
    assign res_flip    = flip_q;
endmodule

// File: rtl/fmasr_checker.sv
module fmasr_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic [EXP_W+FRAC_W:0] op_c,
    input logic [2:0]            neg_ctl,
    input logic [1:0]            rnd_mode,
    input logic                  ftz_en,
    input logic [EXP_W+FRAC_W:0] res_word,
    input logic                  flg_invalid,
    input logic                  flg_outdenorm,
    input logic                  pass_thru,
    input logic                  prod_sign,
    input logic                  addend_sign,
    input logic                  res_flip
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] DEFQ = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic k_nan(input logic [W-1:0] x);
        return (&x[W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
    endfunction
    function automatic logic k_inf(input logic [W-1:0] x);
        return (&x[W-2:FRAC_W]) && !(|x[FRAC_W-1:0]);
    endfunction
    function automatic logic k_zero(input logic [W-1:0] x);
        return x[W-2:0] == '0;
    endfunction

    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    logic x_nan, x_iz, x_pz, x_pinf, x_cinf, x_cz, x_csub, x_sdiff;
    assign x_nan   = k_nan(op_a) || k_nan(op_b) || k_nan(op_c);
    assign x_iz    = (k_zero(op_a) && k_inf(op_b)) || (k_inf(op_a) && k_zero(op_b));
    assign x_pz    = k_zero(op_a) || k_zero(op_b);
    assign x_pinf  = k_inf(op_a) || k_inf(op_b);
    assign x_cinf  = k_inf(op_c);
    assign x_cz    = k_zero(op_c);
    assign x_csub  = (op_c[W-2:FRAC_W] == '0) && !x_cz;
    assign x_sdiff = (op_a[W-1] ^ op_b[W-1] ^ neg_ctl[1]) != (op_c[W-1] ^ neg_ctl[0]);

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(x_nan) |-> (&res_word[W-2:FRAC_W-1]) && !pass_thru); // R2

    AST_NAN_FIRST_A: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(k_nan(op_a)) |-> res_word == ($past(op_a) | QBIT)); // R2

    AST_INFZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(x_iz && !x_nan) |-> flg_invalid && res_word == DEFQ); // R3

    AST_SIGN_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> prod_sign == $past(op_a[W-1] ^ op_b[W-1] ^ neg_ctl[1])
                   && addend_sign == $past(op_c[W-1] ^ neg_ctl[0])
                   && res_flip == $past(neg_ctl[2])); // R4

    AST_INF_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(!x_nan && !x_iz && x_cinf && x_pinf && x_sdiff)
        |-> flg_invalid && res_word == DEFQ); // R5

    AST_ZERO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(!x_nan && !x_iz && x_pz && x_cz && x_sdiff)
        |-> res_word == {($past(rnd_mode) == 2'b10) ^ res_flip, {(W-1){1'b0}}}); // R8

    AST_FLUSH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(!x_nan && !x_iz && x_pz && x_csub && ftz_en)
        |-> flg_outdenorm && res_word[W-2:0] == '0); // R9

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        pass_thru |-> res_word == '0 && !flg_invalid && !flg_outdenorm); // R11

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flg_invalid, flg_outdenorm, pass_thru})); // R11
endmodule

bind fma_special_resolve fmasr_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_a          (op_a),
    .op_b          (op_b),
    .op_c          (op_c),
    .neg_ctl       (neg_ctl),
    .rnd_mode      (rnd_mode),
    .ftz_en        (ftz_en),
    .res_word      (res_word),
    .flg_invalid   (flg_invalid),
    .flg_outdenorm (flg_outdenorm),
    .pass_thru     (pass_thru),
    .prod_sign     (prod_sign),
    .addend_sign   (addend_sign),
    .res_flip      (res_flip)
);

// File: tb/fma_special_resolve_bench.sv
module fma_special_resolve_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic [2:0]  neg_ctl = '0;
    logic [1:0]  rnd_mode = '0;
    logic        ftz_en = 1'b0;
    logic [31:0] res_word;
    logic        flg_invalid, flg_outdenorm, pass_thru, prod_sign, addend_sign, res_flip;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fma_special_resolve u_fma_special_resolve (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b), .op_c (op_c),
        .neg_ctl (neg_ctl), .rnd_mode (rnd_mode), .ftz_en (ftz_en),
        .res_word (res_word), .flg_invalid (flg_invalid), .flg_outdenorm (flg_outdenorm),
        .pass_thru (pass_thru), .prod_sign (prod_sign), .addend_sign (addend_sign),
        .res_flip (res_flip)
    );

    function automatic logic [31:0] pick_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'h3F80_0000;
            5: return 32'hBFC0_0000;
            6: return 32'h0000_0001;
            7: return 32'h807F_FFFF;
            8: return 32'h7FC0_0001;
            9: return 32'hFF80_0005;
            10: return 32'h7F80_0003;
            default: return 32'hFFC1_2345;
        endcase
    endfunction

    function automatic bit is_nan(input logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic bit is_inf(input logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] == 0;
    endfunction
    function automatic bit is_zero(input logic [31:0] x);
        return x[30:0] == 0;
    endfunction

    // Independent model of the requirements; returns {res, inv, od, pass}
    task automatic model(input logic [31:0] a, b, c, input logic [2:0] n,
                         input logic [1:0] rm, input logic ftz,
                         output logic [34:0] exp_v, output logic [2:0] exp_s,
                         output string tag);
        logic ps, cs, rf, iz, s;
        ps = a[31] ^ b[31] ^ n[1];
        cs = c[31] ^ n[0];
        rf = n[2];
        exp_s = {ps, cs, rf};
        iz = (is_zero(a) && is_inf(b)) || (is_inf(a) && is_zero(b));
        if (is_nan(a) || is_nan(b) || is_nan(c)) begin
            logic [31:0] w;
            w = is_nan(a) ? a : (is_nan(b) ? b : c);
            exp_v = {w | 32'h0040_0000,
                     (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]) || (is_nan(c) && !c[22]) || iz,
                     1'b0, 1'b0};
            tag = "R2";
        end else if (iz) begin
            exp_v = {32'h7FC0_0000, 3'b100}; tag = "R3";
        end else if (is_inf(c)) begin
            if ((is_inf(a) || is_inf(b)) && ps != cs) begin
                exp_v = {32'h7FC0_0000, 3'b100}; tag = "R5";
            end else begin
                exp_v = {cs ^ rf, 8'hFF, 23'd0, 3'b000}; tag = "R6";
            end
        end else if (is_inf(a) || is_inf(b)) begin
            exp_v = {ps ^ rf, 8'hFF, 23'd0, 3'b000}; tag = "R7";
        end else if (is_zero(a) || is_zero(b)) begin
            if (is_zero(c)) begin
                s = (ps == cs) ? ps : (rm == 2'b10);
                exp_v = {s ^ rf, 31'd0, 3'b000}; tag = "R8";
            end else if (c[30:23] == 0 && ftz) begin
                exp_v = {cs ^ rf, 31'd0, 3'b010}; tag = "R9";
            end else begin
                exp_v = {cs ^ rf, c[30:0], 3'b000}; tag = "R10";
            end
        end else begin
            exp_v = {32'd0, 3'b001}; tag = "R11";
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [34:0] pend_v;
        logic [2:0]  pend_s;
        string       pend_tag;
        bit          have_prev;
        logic [34:0] got_v;
        logic [2:0]  got_s;

        have_prev = 0;
        pend_v = '0; pend_s = '0; pend_tag = "";
        repeat (3) @(negedge clk);
        op_a = 32'h7FC0_0000; neg_ctl = 3'b111;
        @(negedge clk);
        // R1: outputs held at zero during reset
        checks++;
        got_v = {res_word, flg_invalid, flg_outdenorm, pass_thru};
        got_s = {prod_sign, addend_sign, res_flip};
        if (got_v != 0 || got_s != 0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%b expected=0/000", got_v, got_s);
        end
        rst_n = 1'b1;

        for (int ia = 0; ia < 12; ia++)
            for (int ib = 0; ib < 12; ib++)
                for (int ic = 0; ic < 12; ic++)
                    for (int nn = 0; nn < 8; nn++)
                        for (int rr = 0; rr < 4; rr++)
                            for (int ff = 0; ff < 2; ff++) begin
                                @(negedge clk);
                                if (have_prev) begin
                                    got_v = {res_word, flg_invalid, flg_outdenorm, pass_thru};
                                    got_s = {prod_sign, addend_sign, res_flip};
                                    checks++;
                                    if (got_v != pend_v) begin
                                        errors++;
                                        $display("FAIL %s a=%h b=%h c=%h actual=%h expected=%h",
                                                 pend_tag, op_a, op_b, op_c, got_v, pend_v);
                                    end
                                    checks++;
                                    if (got_s != pend_s) begin
                                        errors++;
                                        $display("FAIL R4 signs actual=%b expected=%b", got_s, pend_s);
                                    end
                                end
                                op_a = pick_val(ia);
                                op_b = pick_val(ib);
                                op_c = pick_val(ic);
                                neg_ctl = 3'(nn);
                                rnd_mode = 2'(rr);
                                ftz_en = ff[0];
                                model(op_a, op_b, op_c, neg_ctl, rnd_mode, ftz_en,
                                      pend_v, pend_s, pend_tag);
                                have_prev = 1;
                            end
        @(negedge clk);
        got_v = {res_word, flg_invalid, flg_outdenorm, pass_thru};
        got_s = {prod_sign, addend_sign, res_flip};
        checks++;
        if (got_v != pend_v || got_s != pend_s) begin
            errors++;
            $display("FAIL %s final actual=%h/%b expected=%h/%b", pend_tag, got_v, got_s, pend_v, pend_s);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule